// File: doc/BRIEF.md
# Multicycle Processor Sequencer

This block is the control sequencer for a 16-bit processor whose datapath takes several clock cycles per instruction. It reads the 4-bit opcode held in the instruction register. Each cycle it drives the datapath's select lines and write enables. The instruction flow is fetch, then decode, then a short run of execution cycles that depends on the instruction class, then back to fetch.

The sequencer is a Moore machine. Its outputs are a function of the current state. In the two execute states, the low three opcode bits also pass straight through as the ALU function code. The present state is exported so that the surrounding logic and the bench can follow the sequence. State codes: 0 fetch, 1 decode, 2 address compute, 3 memory read, 4 load write-back, 5 memory write, 6 register execute, 7 register write-back, 8 branch, 9 jump, 10 immediate execute, 11 immediate write-back, 12 halt.

Opcode classes:

| Class | Opcodes |
|---|---|
| Register | 0000–0101 and 1110 |
| Load | 0110 |
| Store | 0111 |
| Immediate | 1000–1010 |
| Branch | 1011 |
| Halt | 1100 |
| Jump | 1101 and 1111 |

Top module: `mcyc_ctrl`

## Requirements

Output vector below means {pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, dst_sel, reg_wr, wb_sel, alu_a_sel, alu_b_sel, alu_op, pc_src}. Any output not named for a state is 0 in that state.

- R1: While rst_ni is low the state is 0 (fetch), and the state is forced to 0 asynchronously when reset is asserted.
- R2: In state 0, ir_wr=1, pc_wr=1 and alu_b_sel=01, and the next state is 1.
- R3: In state 1, alu_b_sel=10. The next state is chosen by opcode:
  - load and store go to 2;
  - register opcodes go to 6;
  - immediate opcodes go to 10;
  - branch goes to 8;
  - jump opcodes go to 9;
  - halt goes to 12.
- R4: In state 2, alu_a_sel=1 and alu_b_sel=10. The next state is 5 for store (0111) and 3 otherwise.
- R5: In state 3, addr_sel=1 and the next state is 4. In state 4, reg_wr=1, wb_sel=1 and dst_sel=0, and the next state is 0.
- R6: In state 5, mem_wr=1 and addr_sel=1, and the next state is 0.
- R7: In state 6, alu_a_sel=1, alu_b_sel=00 and alu_op equals opcode[2:0], and the next state is 7. In state 7, reg_wr=1 and dst_sel=1, and the next state is 0.
- R8: In state 10, alu_a_sel=1, alu_b_sel=10 and alu_op equals opcode[2:0], and the next state is 11. In state 11, reg_wr=1 with dst_sel=0 and wb_sel=0, and the next state is 0.
- R9: In state 8, alu_a_sel=1, alu_op=011, pc_wr_cond=1 and pc_src=01, and the next state is 0.
- R10: In state 9, pc_wr=1 and pc_src=10, and the next state is 0.
- R11: State 12 keeps all outputs at 0 and holds until reset.
- R12: Outputs not named for the current state are 0. At most one of ir_wr, mem_wr, reg_wr and pc_wr_cond is high in any cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| opcode_i | input | 4 | Opcode from the instruction register |
| state_o | output | 4 | Current state code |
| pc_wr_o | output | 1 | Unconditional program counter write |
| pc_wr_cond_o | output | 1 | Program counter write if the ALU result is zero |
| addr_sel_o | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_wr_o | output | 1 | Memory write enable |
| ir_wr_o | output | 1 | Instruction register write enable |
| dst_sel_o | output | 1 | Destination register field select: 1 rd, 0 rt |
| reg_wr_o | output | 1 | Register file write enable |
| wb_sel_o | output | 1 | Write-back source: 1 memory data, 0 ALU result |
| alu_a_sel_o | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B select |
| alu_op_o | output | 3 | ALU function code |
| pc_src_o | output | 2 | Next program counter source select |

## Verification

The bench builds the block with its only configuration, a 4-bit opcode and a 3-bit ALU function. That small configuration puts an exhaustive sweep of all sixteen opcodes within reach. Each opcode is walked through its full state path, and every output is compared against an independent model in every cycle. The sweep also covers:

- the opcode-dependent ALU codes in both execute states;
- the split between load and store in the address state;
- the sticky halt state;
- a reset asserted in the middle of an instruction.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned ALU_W   = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MRD    = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWR    = 4'd5,
    ST_REXEC  = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRN    = 4'd8,
    ST_JMP    = 4'd9,
    ST_IEXEC  = 4'd10,
    ST_IWB    = 4'd11,
    ST_HALT   = 4'd12
  } state_e;

  localparam logic [OP_W-1:0] OP_ADD  = 4'b0000;
  localparam logic [OP_W-1:0] OP_AND  = 4'b0001;
  localparam logic [OP_W-1:0] OP_OR   = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b0011;
  localparam logic [OP_W-1:0] OP_NOT  = 4'b0100;
  localparam logic [OP_W-1:0] OP_XOR  = 4'b0101;
  localparam logic [OP_W-1:0] OP_LD   = 4'b0110;
  localparam logic [OP_W-1:0] OP_ST   = 4'b0111;
  localparam logic [OP_W-1:0] OP_ADDI = 4'b1000;
  localparam logic [OP_W-1:0] OP_ANDI = 4'b1001;
  localparam logic [OP_W-1:0] OP_ORI  = 4'b1010;
  localparam logic [OP_W-1:0] OP_BEQ  = 4'b1011;
  localparam logic [OP_W-1:0] OP_HLT  = 4'b1100;
  localparam logic [OP_W-1:0] OP_JMP  = 4'b1101;
  localparam logic [OP_W-1:0] OP_SLT  = 4'b1110;
  localparam logic [OP_W-1:0] OP_JAL  = 4'b1111;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'b000;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b011;

  localparam logic [SEL_W-1:0] B_REG  = 2'b00;
  localparam logic [SEL_W-1:0] B_FOUR = 2'b01;
  localparam logic [SEL_W-1:0] B_IMM  = 2'b10;

  localparam logic [SEL_W-1:0] PC_ALU = 2'b00;
  localparam logic [SEL_W-1:0] PC_OUT = 2'b01;
  localparam logic [SEL_W-1:0] PC_TGT = 2'b10;

  typedef struct packed {
    logic             pc_wr;
    logic             pc_wr_cond;
    logic             addr_sel;
    logic             mem_wr;
    logic             ir_wr;
    logic             dst_sel;
    logic             reg_wr;
    logic             wb_sel;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [ALU_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcyc_ctrl_nxt.sv
module mcyc_ctrl_nxt
  import mcyc_ctrl_pkg::*;
(
  input  state_e          state_i,
  input  logic [OP_W-1:0] opcode_i,
  output state_e          state_o
);
  always_comb begin
    unique case (state_i)
      ST_FETCH:  state_o = ST_DECODE;
      ST_DECODE: begin
        unique case (opcode_i)
          OP_LD, OP_ST:            state_o = ST_MADDR;
          OP_ADDI, OP_ANDI, OP_ORI: state_o = ST_IEXEC;
          OP_BEQ:                  state_o = ST_BRN;
          OP_JMP, OP_JAL:          state_o = ST_JMP;
          OP_HLT:                  state_o = ST_HALT;
          default:                 state_o = ST_REXEC;
        endcase
      end
      ST_MADDR:  state_o = (opcode_i == OP_ST) ? ST_MWR : ST_MRD;
      ST_MRD:    state_o = ST_LDWB;
      ST_REXEC:  state_o = ST_RWB;
      ST_IEXEC:  state_o = ST_IWB;
      ST_HALT:   state_o = ST_HALT;
      default:   state_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl_dec.sv
module mcyc_ctrl_dec
  import mcyc_ctrl_pkg::*;
(
  input  state_e           state_i,
  input  logic [ALU_W-1:0] alu_fn_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.alu_b_sel = B_FOUR;
        ctrl_o.alu_op    = ALU_ADD;
        ctrl_o.pc_src    = PC_ALU;
      end
      ST_DECODE: ctrl_o.alu_b_sel = B_IMM;
      ST_MADDR: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = B_IMM;
      end
      ST_MRD: ctrl_o.addr_sel = 1'b1;
      ST_LDWB: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_MWR: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_REXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = B_REG;
        ctrl_o.alu_op    = alu_fn_i;
      end
      ST_RWB: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.dst_sel = 1'b1;
      end
      ST_BRN: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_op     = ALU_SUB;
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.pc_src     = PC_OUT;
      end
      ST_JMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = PC_TGT;
      end
      ST_IEXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = B_IMM;
        ctrl_o.alu_op    = alu_fn_i;
      end
      ST_IWB: ctrl_o.reg_wr = 1'b1;
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  output logic [STATE_W-1:0] state_o,
  output logic               pc_wr_o,
  output logic               pc_wr_cond_o,
  output logic               addr_sel_o,
  output logic               mem_wr_o,
  output logic               ir_wr_o,
  output logic               dst_sel_o,
  output logic               reg_wr_o,
  output logic               wb_sel_o,
  output logic               alu_a_sel_o,
  output logic [SEL_W-1:0]   alu_b_sel_o,
  output logic [ALU_W-1:0]   alu_op_o,
  output logic [SEL_W-1:0]   pc_src_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  mcyc_ctrl_nxt u_nxt (
    .state_i  (state_q),
    .opcode_i (opcode_i),
    .state_o  (state_d)
  );

  mcyc_ctrl_dec u_dec (
    .state_i  (state_q),
    .alu_fn_i (opcode_i[ALU_W-1:0]),
    .ctrl_o   (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign pc_wr_o      = ctrl.pc_wr;
  assign pc_wr_cond_o = ctrl.pc_wr_cond;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_wr_o     = ctrl.mem_wr;
  assign ir_wr_o      = ctrl.ir_wr;
  assign dst_sel_o    = ctrl.dst_sel;
  assign reg_wr_o     = ctrl.reg_wr;
  assign wb_sel_o     = ctrl.wb_sel;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign pc_src_o     = ctrl.pc_src;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk
  import mcyc_ctrl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [OP_W-1:0]    opcode_i,
  input logic [STATE_W-1:0] state_o,
  input logic               pc_wr_o,
  input logic               pc_wr_cond_o,
  input logic               addr_sel_o,
  input logic               mem_wr_o,
  input logic               ir_wr_o,
  input logic               dst_sel_o,
  input logic               reg_wr_o,
  input logic               wb_sel_o,
  input logic               alu_a_sel_o,
  input logic [SEL_W-1:0]   alu_b_sel_o,
  input logic [ALU_W-1:0]   alu_op_o,
  input logic [SEL_W-1:0]   pc_src_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> state_o == ST_FETCH);

  // R2
  fetch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_FETCH |=> state_o == ST_DECODE);

  // R2
  fetch_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_FETCH |-> ir_wr_o && pc_wr_o && !addr_sel_o &&
                            alu_b_sel_o == B_FOUR && pc_src_o == PC_ALU);

  // R4
  load_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_MADDR && opcode_i == OP_LD |=> state_o == ST_MRD);

  // R5
  load_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_LDWB |-> reg_wr_o && wb_sel_o && !dst_sel_o);

  // R6
  store_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_MWR |=> state_o == ST_FETCH);

  // R7
  rtype_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_RWB |-> reg_wr_o && dst_sel_o && !wb_sel_o);

  // R8
  imm_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_IEXEC |-> alu_a_sel_o && alu_b_sel_o == B_IMM &&
                            alu_op_o == opcode_i[ALU_W-1:0]);

  // R9
  branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_BRN |-> pc_wr_cond_o && !pc_wr_o &&
                          pc_src_o == PC_OUT && alu_op_o == ALU_SUB);

  // R10
  jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_JMP |-> pc_wr_o && pc_src_o == PC_TGT);

  // R11
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_HALT |=> state_o == ST_HALT);

  // R11
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_HALT |-> !(pc_wr_o || pc_wr_cond_o || mem_wr_o ||
                             reg_wr_o || ir_wr_o));

  // R12
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_wr_o, mem_wr_o, reg_wr_o, pc_wr_cond_o}));
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (.*);

// File: tb/mcyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcyc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [3:0] st;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, dst_sel, reg_wr, wb_sel, alu_a;
  logic [1:0] alu_b, pc_src;
  logic [2:0] alu_op;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mcyc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(op), .state_o(st),
    .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .addr_sel_o(addr_sel),
    .mem_wr_o(mem_wr), .ir_wr_o(ir_wr), .dst_sel_o(dst_sel),
    .reg_wr_o(reg_wr), .wb_sel_o(wb_sel), .alu_a_sel_o(alu_a),
    .alu_b_sel_o(alu_b), .alu_op_o(alu_op), .pc_src_o(pc_src)
  );

  function automatic string req_of(int s);
    case (s)
      0: return "R2";  1: return "R3";  2: return "R4";
      3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
      8: return "R9";  9: return "R10"; 10, 11: return "R8";
      default: return "R11";
    endcase
  endfunction

  // {pc_wr,pc_wr_cond,addr_sel,mem_wr,ir_wr,dst_sel,reg_wr,wb_sel,alu_a,alu_b,alu_op,pc_src}; R12 zeros by default
  function automatic logic [16:0] expect_out(int s, logic [3:0] o);
    int pw = 0, pwc = 0, ad = 0, mw = 0, iw = 0, ds = 0, rw = 0, wb = 0, aa = 0;
    int bb = 0, fn = 0, ps = 0;
    case (s)
      0:  begin iw = 1; pw = 1; bb = 1; end
      1:  bb = 2;
      2:  begin aa = 1; bb = 2; end
      3:  ad = 1;
      4:  begin rw = 1; wb = 1; end
      5:  begin mw = 1; ad = 1; end
      6:  begin aa = 1; fn = int'(o) % 8; end
      7:  begin rw = 1; ds = 1; end
      8:  begin aa = 1; fn = 3; pwc = 1; ps = 1; end
      9:  begin pw = 1; ps = 2; end
      10: begin aa = 1; bb = 2; fn = int'(o) % 8; end
      11: rw = 1;
      default: ;
    endcase
    return {pw[0], pwc[0], ad[0], mw[0], iw[0], ds[0], rw[0], wb[0], aa[0],
            bb[1:0], fn[2:0], ps[1:0]};
  endfunction

  task automatic check(int exp_s, string req);
    logic [16:0] got, exp;
    got = {pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, dst_sel, reg_wr, wb_sel,
           alu_a, alu_b, alu_op, pc_src};
    exp = expect_out(exp_s, op);
    total++;
    if (int'(st) != exp_s) begin
      bad++;
      $display("FAIL %s state op=%b actual=%0d expected=%0d", req, op, st, exp_s);
    end
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s outputs state=%0d op=%b actual=%b expected=%b", req, exp_s, op, got, exp);
    end
  endtask

  task automatic build_path(logic [3:0] o, ref int q[$]);
    q = {0, 1};
    case (o)
      4'b0110: q = {q, 2, 3, 4};
      4'b0111: q = {q, 2, 5};
      4'b1000, 4'b1001, 4'b1010: q = {q, 10, 11};
      4'b1011: q.push_back(8);
      4'b1101, 4'b1111: q.push_back(9);
      4'b1100: q = {q, 12, 12, 12, 12, 12};
      default: q = {q, 6, 7};
    endcase
  endtask

  task automatic run_instr(logic [3:0] o);
    int q[$];
    op = o;
    build_path(o, q);
    while (q.size() > 0) begin
      int s = q.pop_front();
      check(s, req_of(s));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, "R1");
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++) begin
      if (o != 12) run_instr(4'(o));
    end
    run_instr(4'b0101);
    run_instr(4'b1000);
    run_instr(4'b1010);
    begin : mid_reset
      op = 4'b0110;
      check(0, "R2");
      @(negedge clk);
      check(1, "R3");
      @(negedge clk);
      check(2, "R4");
      #1 rst_n = 1'b0;
      #0.5 check(0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
    end
    run_instr(4'b0111);
    run_instr(4'b1100);
    op = 4'b0110;
    check(12, "R11");
    #1 rst_n = 1'b0;
    #0.5 check(0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    run_instr(4'b0110);
    run_instr(4'b1110);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule